// File: doc/BRIEF.md
# Fractional-Resolution PWM Generator with Frame Dithering

This block produces one PWM waveform whose period and duty can be set more finely than a single clock count. Both the period word and the compare word carry a low-order fractional field whose width is chosen by a 2-bit resolution selector. The block groups frames into a dither cycle of 16, 32 or 64 frames. Within that cycle, a chosen subset of frames is lengthened by one count, and separately a chosen subset has its high time lengthened by one count. Averaged over the cycle, the period and the duty then equal the fractional setting.

Each frame has a counter running from zero up to the effective period, so a frame lasts effective-period-plus-one clocks. The output stays high while that counter is below the effective compare value. A one-clock strobe marks the first clock of every frame. Period, compare and resolution are copied into holding registers only at the boundary between dither cycles, so a new setting always starts on a clean cycle.

Top module: `dpwm_top`

## Requirements
- R1: While `rst_i` is high, `pwm_o` and `frame_o` are 0. The first frame begins on the first rising clock edge after `rst_i` falls, so `frame_o` is 1 in the clock that follows that edge.
- R2: Resolution code 0 turns dithering off. Every frame lasts `per_i`+1 clocks, and `pwm_o` is high for the first `cmp_i` clocks of it.
- R3: Resolution code 1 gives a 16-frame dither cycle. The fraction is bits [3:0] of each word and the integer part is the word shifted right by 4.
- R4: Resolution code 2 gives a 32-frame dither cycle. The fraction is bits [4:0] and the integer part is the word shifted right by 5.
- R5: Resolution code 3 gives a 64-frame dither cycle. The fraction is bits [5:0] and the integer part is the word shifted right by 6.
- R6: Take frame k of a cycle of N frames with fraction F. That frame gets one extra count exactly when floor((k+1)F/N) > floor(kF/N). Over the whole cycle, the frame lengths therefore add up to N*(integer period + 1) + F.
- R7: The period fraction and the compare fraction are spread independently, each following the R6 rule with its own fraction.
- R8: `pwm_o` is high for the first min(effective compare, frame length) clocks of each frame and low for the rest. A compare of zero keeps it low for the whole frame. A compare at or above the frame length keeps it high for the whole frame.
- R9: `frame_o` is high for exactly the first clock of each frame.
- R10: Period, compare and resolution are sampled only at the edge that starts a dither cycle. With code 0, every frame is a cycle. Changes made at any other time do not affect the waveform until the next cycle starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| per_i | input | W | Period word: integer part above the fractional field |
| cmp_i | input | W | Compare word: same layout as the period word |
| res_i | input | 2 | Resolution code: 0 off, 1 sixteen frames, 2 thirty-two frames, 3 sixty-four frames |
| pwm_o | output | 1 | PWM waveform |
| frame_o | output | 1 | Strobe in the first clock of each frame |

## Verification
Three things can happen on the same clock edge: the frame counter wraps, the last frame of a dither cycle ends, and the holding registers reload while both accumulators restart. A setting that changes in the final clock of a frame therefore lands exactly on that shared edge. The bench forces this collision with resolution code 0, where every wrap also ends a cycle. It changes the inputs during the last clock of a frame and checks that the very next frame already carries the new length and high time. In a separate run at 16 frames per cycle, a change made partway through a cycle must leave the remaining frames of that cycle unchanged. It must then appear in full from the first frame of the next cycle.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

   localparam int FRAC_W = 6;

   typedef enum logic [1:0] {
      DRES_OFF = 2'd0,
      DRES_16  = 2'd1,
      DRES_32  = 2'd2,
      DRES_64  = 2'd3
   } dres_e;

   function automatic int unsigned dbits(dres_e m);
      case (m)
         DRES_16: return 4;
         DRES_32: return 5;
         DRES_64: return 6;
         default: return 0;
      endcase
   endfunction

   function automatic logic [FRAC_W-1:0] dmask(dres_e m);
      logic [FRAC_W:0] one;
      one = (FRAC_W+1)'(1) << dbits(m);
      return FRAC_W'(one - (FRAC_W+1)'(1));
   endfunction

endpackage

// File: rtl/dpwm_shadow.sv
module dpwm_shadow
   import dpwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         load_i,
   input  logic [W-1:0] per_i,
   input  logic [W-1:0] cmp_i,
   input  dres_e        mode_i,
   output logic [W-1:0] per_o,
   output logic [W-1:0] cmp_o,
   output dres_e        mode_o
);

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         per_o  <= '0;
         cmp_o  <= '0;
         mode_o <= DRES_OFF;
      end else if (load_i) begin
         per_o  <= per_i;
         cmp_o  <= cmp_i;
         mode_o <= mode_i;
      end
   end

endmodule

// File: rtl/dpwm_split.sv
module dpwm_split
   import dpwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0]      val_i,
   input  dres_e             mode_i,
   output logic [W-1:0]      int_o,
   output logic [FRAC_W-1:0] frac_o
);

   always_comb begin
      int_o  = val_i >> dbits(mode_i);
      frac_o = val_i[FRAC_W-1:0] & dmask(mode_i);
   end

endmodule

// File: rtl/dpwm_dither_acc.sv
module dpwm_dither_acc
   import dpwm_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_i,
   input  dres_e             mode_i,
   input  logic [FRAC_W-1:0] frac_i,
   input  logic              step_i,
   input  logic              restart_i,
   output logic              extra_o,
   output logic [FRAC_W-1:0] acc_o
);

   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   sum;
   logic [FRAC_W:0]   limit;
   logic [FRAC_W-1:0] acc_nxt;

   always_comb begin
      sum     = {1'b0, acc_q} + {1'b0, frac_i};
      limit   = (FRAC_W+1)'(1) << dbits(mode_i);
      extra_o = (sum >= limit);
      acc_nxt = sum[FRAC_W-1:0] & dmask(mode_i);
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)
         acc_q <= '0;
      else if (restart_i)
         acc_q <= '0;
      else if (step_i)
         acc_q <= acc_nxt;
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/dpwm_frame_ctr.sv
module dpwm_frame_ctr
   import dpwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  dres_e        mode_i,
   input  logic [W:0]   per_eff_i,
   output logic         running_o,
   output logic [W:0]   cnt_o,
   output logic         wrap_o,
   output logic         cyc_load_o
);

   logic              run_q;
   logic [W:0]        cnt_q;
   logic [FRAC_W-1:0] fidx_q;
   logic              last_frame;

   always_comb begin
      last_frame = (fidx_q == dmask(mode_i));
      wrap_o     = run_q && (cnt_q == per_eff_i);
      cyc_load_o = !run_q || (wrap_o && last_frame);
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         run_q  <= 1'b0;
         cnt_q  <= '0;
         fidx_q <= '0;
      end else if (!run_q) begin
         run_q  <= 1'b1;
         cnt_q  <= '0;
         fidx_q <= '0;
      end else if (wrap_o) begin
         cnt_q  <= '0;
         fidx_q <= last_frame ? '0 : fidx_q + 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign running_o = run_q;
   assign cnt_o     = cnt_q;

endmodule

// File: rtl/dpwm_top.sv
module dpwm_top
   import dpwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] per_i,
   input  logic [W-1:0] cmp_i,
   input  logic [1:0]   res_i,
   output logic         pwm_o,
   output logic         frame_o
);

   localparam int NCH = 2;
   localparam int CH_PER = 0;
   localparam int CH_CMP = 1;

   if (W < FRAC_W + 2) begin : g_bad_width
      $error("dpwm_top: W must leave integer bits above the fraction");
   end

   logic        running;
   logic        frm_wrap;
   logic        cyc_load;
   logic [W:0]  cnt;
   logic [W-1:0] per_s;
   logic [W-1:0] cmp_s;
   dres_e       mode_s;

   logic [NCH-1:0][W-1:0]      raw_s;
   logic [NCH-1:0][W:0]        eff;
   logic [NCH-1:0][FRAC_W-1:0] acc_w;

   dpwm_shadow #(.W(W)) u_shadow (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (cyc_load),
      .per_i  (per_i),
      .cmp_i  (cmp_i),
      .mode_i (dres_e'(res_i)),
      .per_o  (per_s),
      .cmp_o  (cmp_s),
      .mode_o (mode_s)
   );

   assign raw_s[CH_PER] = per_s;
   assign raw_s[CH_CMP] = cmp_s;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [W-1:0]      int_w;
      logic [FRAC_W-1:0] frac_w;
      logic              extra_w;

      dpwm_split #(.W(W)) u_split (
         .val_i  (raw_s[c]),
         .mode_i (mode_s),
         .int_o  (int_w),
         .frac_o (frac_w)
      );

      dpwm_dither_acc u_acc (
         .clk_i     (clk_i),
         .rst_i     (rst_i),
         .mode_i    (mode_s),
         .frac_i    (frac_w),
         .step_i    (frm_wrap),
         .restart_i (cyc_load),
         .extra_o   (extra_w),
         .acc_o     (acc_w[c])
      );

      assign eff[c] = {1'b0, int_w} + (W+1)'(extra_w);
   end

   dpwm_frame_ctr #(.W(W)) u_ctr (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .mode_i     (mode_s),
      .per_eff_i  (eff[CH_PER]),
      .running_o  (running),
      .cnt_o      (cnt),
      .wrap_o     (frm_wrap),
      .cyc_load_o (cyc_load)
   );

   assign pwm_o   = running && (cnt < eff[CH_CMP]);
   assign frame_o = running && (cnt == '0);

endmodule

// File: rtl/dpwm_chk.sv
module dpwm_chk
   import dpwm_pkg::*;
#(
   parameter int W = 16
) (
   input logic                   clk_i,
   input logic                   rst_i,
   input logic                   pwm_o,
   input logic                   frame_o,
   input logic                   running,
   input logic                   frm_wrap,
   input logic                   cyc_load,
   input logic [W-1:0]           per_s,
   input logic [W-1:0]           cmp_s,
   input dres_e                  mode_s,
   input logic [1:0][FRAC_W-1:0] acc_w
);

   // R1: quiet outputs during reset
   always @(posedge clk_i) begin
      if (rst_i) begin
         a_r1_quiet_in_reset: assert (!pwm_o && !frame_o)
            else $error("R1 outputs active in reset");
      end
   end

   a_r10_shadow_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !cyc_load |=> ($stable(per_s) && $stable(cmp_s) && $stable(mode_s)));

   a_r6_acc_restart: assert property (@(posedge clk_i) disable iff (rst_i)
      cyc_load |=> (acc_w[0] == '0 && acc_w[1] == '0));

   a_r6_acc_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
      ((acc_w[0] & ~dmask(mode_s)) == '0) && ((acc_w[1] & ~dmask(mode_s)) == '0));

   a_r8_rise_at_frame: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(pwm_o) |-> frame_o);

   a_r9_strobe_after_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
      (frame_o && $past(running)) |-> $past(frm_wrap));

endmodule

bind dpwm_top dpwm_chk #(.W(W)) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .pwm_o    (pwm_o),
   .frame_o  (frame_o),
   .running  (running),
   .frm_wrap (frm_wrap),
   .cyc_load (cyc_load),
   .per_s    (per_s),
   .cmp_s    (cmp_s),
   .mode_s   (mode_s),
   .acc_w    (acc_w)
);

// File: tb/dpwm_top_tb.sv
module dpwm_top_tb;

   localparam int W = 16;
   localparam int NV = 7;

   // {mode[33:32], per[31:16], cmp[15:0]}
   localparam logic [33:0] VEC [NV] = '{
      {2'd0, 16'd9,   16'd4},
      {2'd1, 16'd83,  16'd42},
      {2'd2, 16'd241, 16'd96},
      {2'd3, 16'd319, 16'd65},
      {2'd1, 16'd48,  16'd160},
      {2'd0, 16'd5,   16'd0},
      {2'd2, 16'd31,  16'd16}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] per = '0;
   logic [W-1:0] cmp = '0;
   logic [1:0]   res = '0;
   logic         pwm_o;
   logic         frame_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   dpwm_top #(.W(W)) u_dut (
      .clk_i   (clk),
      .rst_i   (rst),
      .per_i   (per),
      .cmp_i   (cmp),
      .res_i   (res),
      .pwm_o   (pwm_o),
      .frame_o (frame_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   function automatic int ext(input int f, input int n, input int k);
      return ((k + 1) * f) / n - (k * f) / n;
   endfunction

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 pwm in reset", int'(pwm_o), 0);
      check("R1 strobe in reset", int'(frame_o), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 first frame strobe", int'(frame_o), 1);
   endtask

   task automatic measure(output int len, output int hi);
      while (!frame_o) @(negedge clk);
      len = 0;
      hi  = 0;
      do begin
         len++;
         if (pwm_o) hi++;
         @(negedge clk);
      end while (!frame_o);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (every requirement) actual=hung expected=finished");
      summary();
   end

   initial begin
      int len, hi;
      @(negedge clk);

      // table walk: R2 to R9
      for (int v = 0; v < NV; v++) begin
         int md, d, n, ip, fp, ic, fc, frames, total, el, eh;
         string mtag;
         md  = int'(VEC[v][33:32]);
         res = VEC[v][33:32];
         per = VEC[v][31:16];
         cmp = VEC[v][15:0];
         d   = (md == 0) ? 0 : md + 3;
         n   = 1 << d;
         ip  = int'(per) >> d;
         fp  = int'(per) & (n - 1);
         ic  = int'(cmp) >> d;
         fc  = int'(cmp) & (n - 1);
         mtag = (md == 0) ? "R2" : (md == 1) ? "R3" : (md == 2) ? "R4" : "R5";
         do_reset();
         frames = (n == 1) ? 4 : n;
         total = 0;
         for (int k = 0; k < frames; k++) begin
            measure(len, hi);
            el = ip + ext(fp, n, k) + 1;
            eh = ic + ext(fc, n, k);
            if (eh > el) eh = el;
            check($sformatf("%s/R6/R9 vec%0d frame%0d length", mtag, v, k), len, el);
            check($sformatf("%s/R7/R8 vec%0d frame%0d high", mtag, v, k), hi, eh);
            total += len;
         end
         if (n > 1)
            check($sformatf("R6 vec%0d cycle total", v), total, n * (ip + 1) + fp);
      end

      // R10: mid-cycle change held until the next 16-frame cycle
      res = 2'd1;
      per = 16'd80;
      cmp = 16'd32;
      do_reset();
      for (int k = 0; k < 3; k++) begin
         measure(len, hi);
         check("R10 pre-change length", len, 6);
      end
      per = 16'd128;
      cmp = 16'd0;
      for (int k = 3; k < 16; k++) begin
         measure(len, hi);
         check("R10 old length kept", len, 6);
         check("R10 old high kept", hi, 2);
      end
      measure(len, hi);
      check("R10 new length at cycle start", len, 9);
      check("R10/R8 new high at cycle start", hi, 0);

      // R2/R10: change lands on the last clock of a plain frame
      res = 2'd0;
      per = 16'd3;
      cmp = 16'd1;
      do_reset();
      measure(len, hi);
      check("R2 plain length", len, 4);
      check("R2 plain high", hi, 1);
      repeat (3) @(negedge clk);
      per = 16'd6;
      cmp = 16'd5;
      measure(len, hi);
      check("R10 boundary new length", len, 7);
      check("R10 boundary new high", hi, 5);

      summary();
   end

endmodule